// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits between one hart's load/store unit and a 32-bit memory port. It handles four kinds of word access: plain load, plain store, reserving load (LR) and conditional store (SC). A reserving load reads the word and arms a single reservation on that aligned word. A conditional store writes memory only while that reservation is still armed for the same word. In that case it returns 0 as the destination value. Otherwise it leaves memory untouched and returns 1, so software can loop back and retry the pair.

A snoop input reports writes made by other agents. A snoop write to the reserved word disarms the reservation, and so does a plain store from this hart to that word. Every conditional store, whether it succeeds or fails, leaves the reservation disarmed. A controller with three states orders the traffic:
- `ST_IDLE` accepts one command.
- `ST_MEM` holds the memory request until it is acknowledged.
- `ST_RESP` presents the result for one cycle.

The controller moves through these transitions:
- `ST_IDLE`→`ST_MEM` on any accepted command that needs memory.
- `ST_IDLE`→`ST_RESP` on a conditional store that fails.
- `ST_MEM`→`ST_RESP` on the acknowledge.
- `ST_RESP`→`ST_IDLE` unconditionally.

Top module: `lrsc_monitor`

## Requirements
- R1: A reserving load (cmd_op=2) returns the addressed memory word on rsp_data and arms the reservation on that word. A plain load (cmd_op=0) returns the word and leaves the reservation alone.
- R2: A conditional store (cmd_op=3) to the armed word performs exactly one memory write (mem_we=1) of cmd_wdata and returns rsp_data=0.
- R3: A conditional store with no armed reservation performs no memory write and returns rsp_data=1.
- R4: Every conditional store disarms the reservation, whether it succeeds or fails, so a second conditional store without a new reserving load fails.
- R5: A conditional store to a word other than the reserved one fails.
- R6: A snoop write (snp_valid=1) to the reserved word disarms the reservation, including a snoop in the same cycle the conditional store is accepted. A snoop to another word has no effect.
- R7: A plain store (cmd_op=1) from this hart to the reserved word disarms the reservation, and the store itself is still written.
- R8: Reservation matching uses address bits [31:2] only, and mem_addr is always driven with bits [1:0] equal to 0.
- R9: After reset the reservation is disarmed, cmd_ready=1, mem_req=0 and rsp_valid=0.
- R10: mem_req stays high with a stable address until mem_ack. rsp_valid is a single-cycle pulse. cmd_ready is high only while neither a memory request nor a response is in progress. A plain store returns rsp_data=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle; command taken when both are high |
| cmd_op | input | 2 | 0 load, 1 store, 2 reserving load, 3 conditional store |
| cmd_addr | input | 32 | Byte address of the access |
| cmd_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | 32 | Load data, or 0/1 code for a conditional store |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Memory read data |
| snp_valid | input | 1 | Write by another agent observed |
| snp_addr | input | 32 | Byte address of the observed write |

## Verification
A snoop write and the acceptance of a conditional store can land in the same cycle. In that cycle the reservation check and its invalidation collide. The bench provokes this by raising snp_valid to the reserved word, at a different byte offset, on the very cycle that it presents the conditional store. It then requires rsp_data=1 with an unchanged memory write count and an unchanged memory word. The bench also lines a snoop up with the cycle that accepts a reserving load, where the arming and the invalidation collide, and judges it by the failure of the following conditional store.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LR    = 2'd2,
        OP_SC    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_RESP = 2'd2
    } state_e;
endpackage

// File: rtl/lrsc_resv.sv
// Single reservation: one valid bit and one word tag.
module lrsc_resv #(
    parameter int TAG_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_lr,
    input  logic             acc_store,
    input  logic             acc_sc,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic             snp_valid,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             resv_hit
);
    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    logic             snp_kill;
    logic             cmd_match;

    assign cmd_match = valid_q && (tag_q == cmd_tag);
    assign snp_kill  = snp_valid && valid_q && (snp_tag == tag_q);
    // A snoop on the same cycle beats the reservation check.
    assign resv_hit  = cmd_match && !snp_kill;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (acc_lr) begin
            tag_q   <= cmd_tag;
            valid_q <= !(snp_valid && (snp_tag == cmd_tag));
        end else if (acc_sc || snp_kill || (acc_store && cmd_match)) begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/lrsc_ctrl.sv
// Command sequencer: accept, memory access, response.
module lrsc_ctrl
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [ADDR_W-OFS_W-1:0] cmd_tag,
    input  logic [DATA_W-1:0]       cmd_wdata,
    input  logic                    resv_hit,
    output logic                    cmd_ready,
    output logic                    acc_lr,
    output logic                    acc_store,
    output logic                    acc_sc,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_data,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic [DATA_W-1:0]       mem_rdata
);
    state_e             state_q, state_n;
    op_e                op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rsp_q;
    logic               accept;
    logic               sc_fail;

    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign acc_lr    = accept && (op_e'(cmd_op) == OP_LR);
    assign acc_store = accept && (op_e'(cmd_op) == OP_STORE);
    assign acc_sc    = accept && (op_e'(cmd_op) == OP_SC);
    assign sc_fail   = acc_sc && !resv_hit;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_n = sc_fail ? ST_RESP : ST_MEM;
            ST_MEM:  if (mem_ack)   state_n = ST_RESP;
            ST_RESP: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            rsp_q   <= '0;
        end else if (accept) begin
            op_q    <= op_e'(cmd_op);
            addr_q  <= {cmd_tag, {OFS_W{1'b0}}};
            wdata_q <= cmd_wdata;
            rsp_q   <= sc_fail ? DATA_W'(1) : '0;
        end else if ((state_q == ST_MEM) && mem_ack && !mem_we) begin
            rsp_q   <= mem_rdata;
        end
    end

    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_MEM);
        mem_we    = (op_q == OP_STORE) || (op_q == OP_SC);
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        rsp_valid = (state_q == ST_RESP);
        rsp_data  = rsp_q;
    end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int OFS_W = $clog2(DATA_W / 8);
    localparam int TAG_W = ADDR_W - OFS_W;

    logic [TAG_W-1:0] cmd_tag;
    logic [TAG_W-1:0] snp_tag;
    logic acc_lr, acc_store, acc_sc, resv_hit;

    assign cmd_tag = cmd_addr[ADDR_W-1:OFS_W];
    assign snp_tag = snp_addr[ADDR_W-1:OFS_W];

    lrsc_resv #(.TAG_W(TAG_W)) u_resv (
        .clk(clk), .rst_n(rst_n),
        .acc_lr(acc_lr), .acc_store(acc_store), .acc_sc(acc_sc),
        .cmd_tag(cmd_tag), .snp_valid(snp_valid), .snp_tag(snp_tag),
        .resv_hit(resv_hit)
    );

    lrsc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_tag(cmd_tag),
        .cmd_wdata(cmd_wdata), .resv_hit(resv_hit), .cmd_ready(cmd_ready),
        .acc_lr(acc_lr), .acc_store(acc_store), .acc_sc(acc_sc),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_op,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    logic last_sc, wrote;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_sc <= 1'b0;
            wrote   <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            last_sc <= (cmd_op == 2'd3);
            wrote   <= 1'b0;
        end else if (mem_req && mem_we && mem_ack) begin
            wrote   <= 1'b1;
        end
    end

    // R2 and R3: success code agrees with whether a write happened
    p_sc_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && last_sc) |-> (rsp_data == (wrote ? '0 : DATA_W'(1))));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_req && !rsp_valid));

    p_word_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/test_lrsc_monitor.sv
`timescale 1ns/1ps
module test_lrsc_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        snp_valid = 1'b0;
    logic [31:0] snp_addr = '0;

    logic [31:0] mem [16];
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] res;
    int          wc0;

    always #10 clk = ~clk;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[5:2]];

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr[5:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    lrsc_monitor i_lrsc_monitor (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .snp_valid(snp_valid), .snp_addr(snp_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                          input logic snp_now, input logic [31:0] sa);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        snp_valid = snp_now; snp_addr = sa;
        @(negedge clk);
        cmd_valid = 1'b0; snp_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        res = rsp_data;
    endtask

    task automatic snoop(input logic [31:0] sa);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = sa;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R9 ready", {31'b0, cmd_ready}, 32'd1);
        check("R9 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R9 mem_req", {31'b0, mem_req}, 32'd0);
        wc0 = wr_cnt;
        run_op(2'd3, 32'h10, 32'h1111, 1'b0, 0);
        check("R9 sc after reset", res, 32'd1);
        check("R9 no write", wr_cnt - wc0, 0);
    endtask

    task automatic t_basic;
        run_op(2'd0, 32'h08, 0, 1'b0, 0);
        check("R1 plain load", res, 32'hA000_0002);
        run_op(2'd2, 32'h10, 0, 1'b0, 0);
        check("R1 lr data", res, 32'hA000_0004);
        wc0 = wr_cnt;
        run_op(2'd3, 32'h10, 32'hCAFE_0001, 1'b0, 0);
        check("R2 sc ok code", res, 32'd0);
        check("R2 one write", wr_cnt - wc0, 1);
        check("R2 mem value", mem[4], 32'hCAFE_0001);
        wc0 = wr_cnt;
        run_op(2'd3, 32'h10, 32'hDEAD_0000, 1'b0, 0);
        check("R4 second sc fails", res, 32'd1);
        check("R3 no write", wr_cnt - wc0, 0);
        check("R3 mem kept", mem[4], 32'hCAFE_0001);
    endtask

    task automatic t_snoop;
        run_op(2'd2, 32'h14, 0, 1'b0, 0);
        snoop(32'h16);
        run_op(2'd3, 32'h14, 32'h5, 1'b0, 0);
        check("R6 snoop same word", res, 32'd1);
        run_op(2'd2, 32'h14, 0, 1'b0, 0);
        snoop(32'h18);
        run_op(2'd3, 32'h14, 32'h6, 1'b0, 0);
        check("R6 snoop other word", res, 32'd0);
        check("R6 write done", mem[5], 32'h6);
        run_op(2'd2, 32'h20, 0, 1'b0, 0);
        wc0 = wr_cnt;
        run_op(2'd3, 32'h20, 32'h7, 1'b1, 32'h21);
        check("R6 collision code", res, 32'd1);
        check("R6 collision no write", wr_cnt - wc0, 0);
        run_op(2'd2, 32'h24, 0, 1'b1, 32'h24);
        run_op(2'd3, 32'h24, 32'h8, 1'b0, 0);
        check("R6 snoop at lr accept", res, 32'd1);
    endtask

    task automatic t_addr;
        run_op(2'd2, 32'h28, 0, 1'b0, 0);
        wc0 = wr_cnt;
        run_op(2'd3, 32'h2C, 32'h9, 1'b0, 0);
        check("R5 other word fails", res, 32'd1);
        check("R5 no write", wr_cnt - wc0, 0);
        run_op(2'd3, 32'h28, 32'h9, 1'b0, 0);
        check("R4 failed sc cleared", res, 32'd1);
        run_op(2'd2, 32'h30, 0, 1'b0, 0);
        run_op(2'd3, 32'h33, 32'hB, 1'b0, 0);
        check("R8 byte offset ignored", res, 32'd0);
        check("R8 aligned write", mem[12], 32'hB);
    endtask

    task automatic t_store;
        run_op(2'd2, 32'h34, 0, 1'b0, 0);
        run_op(2'd1, 32'h35, 32'hC, 1'b0, 0);
        check("R10 store code", res, 32'd0);
        check("R7 store written", mem[13], 32'hC);
        run_op(2'd3, 32'h34, 32'hD, 1'b0, 0);
        check("R7 local store clears", res, 32'd1);
        run_op(2'd2, 32'h38, 0, 1'b0, 0);
        run_op(2'd0, 32'h38, 0, 1'b0, 0);
        check("R1 plain load data", res, 32'hA000_000E);
        run_op(2'd3, 32'h38, 32'hE, 1'b0, 0);
        check("R1 load keeps resv", res, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_snoop();
        t_addr();
        t_store();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule